// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block keeps track of which low-power state the processor has asked for and decides when that state ends. The processor writes a two-bit mode selection and fires a one-cycle entry strobe when its idle instruction executes. The controller then sits in one of three sleep states, raises a clock-stop request for the deeper two, and watches only the wake sources that are legal for the chosen state. When a legal wake arrives, it returns to the running state and emits a one-cycle wake pulse.

Interrupts and the non-maskable interrupt end the light sleep state. The two deep states ignore interrupts and wake only on a general-purpose input pin. The pin must be selected in a per-bit mask and must be seen low for a programmable number of consecutive oscillator ticks. The synchronous reset input doubles as the external reset pin: it returns the block to the running state from any mode. The block has no connection to output pins, so entering or leaving a low-power state cannot disturb them.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is RUN (`lpm_state` = 0), `clk_stop_req` = 0 and `wake_pulse` = 0, whatever mode the block was in.
- R2: In RUN, an `enter` strobe latches `mode_sel` at that edge: 00 gives IDLE (`lpm_state` = 1), 01 gives STANDBY (`lpm_state` = 2), and 10 or 11 gives HALT (`lpm_state` = 3). The new state is visible after that edge.
- R3: An `enter` strobe while the block is not in RUN is ignored, and the state is unchanged.
- R4: In IDLE, `irq` or `nmi` high at an edge returns the block to RUN at that edge, with `wake_pulse` high for that cycle.
- R5: In IDLE, `clk_stop_req` stays 0 and the input pins cannot cause a wake.
- R6: In STANDBY and HALT, `clk_stop_req` is 1. It drops at the same edge that returns the block to RUN.
- R7: In STANDBY and HALT, `irq` and `nmi` have no effect.
- R8: Only pins whose bit in `pin_wake_sel` is 1 take part in a wake. Unselected pins held low never wake the block.
- R9: In STANDBY or HALT, a selected pin must be low on `qual_len`+2 consecutive edges where `osc_tick` is high, so between 2 and 65 ticks. The counter starts at the first edge after the deep state is entered. The wake pulse and the return to RUN happen one edge after the last qualifying tick, which is `qual_len`+3 edges after the pin goes low when `osc_tick` is held at 1.
- R10: If the selected pin goes high before qualification finishes, the count restarts. Edges with `osc_tick` low do not count.
- R11: `wake_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also the external reset wake |
| enter | input | 1 | One-cycle strobe from the idle instruction |
| mode_sel | input | 2 | Requested low-power mode |
| irq | input | 1 | Any enabled interrupt is pending |
| nmi | input | 1 | Non-maskable interrupt recognized |
| pins | input | PIN_W (32) | General-purpose input port, active-low wake |
| pin_wake_sel | input | PIN_W (32) | Per-bit wake enable mask |
| qual_len | input | QW (6) | Qualification length minus 2, in oscillator ticks |
| osc_tick | input | 1 | One-cycle enable marking an oscillator cycle |
| lpm_state | output | 2 | 0 RUN, 1 IDLE, 2 STANDBY, 3 HALT |
| clk_stop_req | output | 1 | Request to gate the processor clock |
| wake_pulse | output | 1 | One-cycle pulse on return to RUN |

## Verification
The qualification count is measured to the exact edge at the shortest setting (2 ticks) and at the longest (65). An off-by-one counter would wake one cycle early or late. A pin that goes high one tick short of the limit, and a stretch with `osc_tick` held low, both catch a counter that fails to restart or that counts every clock. Interrupts raised in both deep modes, low pins in IDLE, and low unselected pins check that each mode keeps to its own wake sources; a design that merged them would wake from the wrong event. Entry strobes inside a sleep state and reset from a deep state check that the mode cannot be changed behind the processor's back.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    LPM_RUN  = 2'd0,
    LPM_IDLE = 2'd1,
    LPM_STBY = 2'd2,
    LPM_HALT = 2'd3
  } lpm_state_e;

  // Mode field: 00 light sleep, 01 standby, 1x halt
  function automatic lpm_state_e decode_mode(input logic [1:0] m);
    if (m[1])      return LPM_HALT;
    else if (m[0]) return LPM_STBY;
    else           return LPM_IDLE;
  endfunction

endpackage

// File: rtl/lpm_pin_qual.sv
module lpm_pin_qual #(
  parameter int PIN_W = 32,
  parameter int QW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [PIN_W-1:0] pins,
  input  logic [PIN_W-1:0] sel,
  input  logic [QW-1:0]    qual_len,
  input  logic             osc_tick,
  output logic             pin_ok
);

  localparam int CW = QW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;
  logic          any_low;

  assign need    = CW'(qual_len) + CW'(2);
  assign any_low = |(~pins & sel);

  always_ff @(posedge clk) begin
    if (rst || !arm || !any_low) begin
      cnt_q  <= '0;
      pin_ok <= 1'b0;
    end else if (osc_tick && !pin_ok) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q + CW'(1) == need) pin_ok <= 1'b1;
    end
  end

  AST_QUAL_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= need) else $error("qual count beyond limit"); // R9

  AST_QUAL_DROPS_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    (arm && !any_low) |=> !pin_ok) else $error("qualified without low pin"); // R10

endmodule

// File: rtl/lpm_wake_fsm.sv
module lpm_wake_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enter,
  input  logic [1:0] mode_sel,
  input  logic       irq,
  input  logic       nmi,
  input  logic       pin_ok,
  output logic [1:0] state_o,
  output logic       deep_o,
  output logic       clk_stop_req,
  output logic       wake_pulse
);

  lpm_state_e state_q, state_d;
  logic       wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      LPM_RUN:  if (enter) state_d = decode_mode(mode_sel);
      LPM_IDLE: if (irq || nmi) begin
                  state_d = LPM_RUN;
                  wake_d  = 1'b1;
                end
      LPM_STBY,
      LPM_HALT: if (pin_ok) begin
                  state_d = LPM_RUN;
                  wake_d  = 1'b1;
                end
      default:  state_d = LPM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= LPM_RUN;
      wake_pulse   <= 1'b0;
      clk_stop_req <= 1'b0;
    end else begin
      state_q      <= state_d;
      wake_pulse   <= wake_d;
      clk_stop_req <= (state_d == LPM_STBY) || (state_d == LPM_HALT);
    end
  end

  assign state_o = state_q;
  assign deep_o  = (state_q == LPM_STBY) || (state_q == LPM_HALT);

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse) else $error("wake pulse too long"); // R11

  AST_WAKE_LANDS_RUN: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (state_q == LPM_RUN && !clk_stop_req)) else $error("wake not in run"); // R4

  AST_DEEP_IGNORES_INT: assert property (@(posedge clk) disable iff (rst)
    (deep_o && !pin_ok) |=> (state_q == $past(state_q))) else $error("deep state left"); // R7

  AST_SLEEP_IGNORES_ENTER: assert property (@(posedge clk) disable iff (rst)
    (state_q != LPM_RUN && enter) |=> (state_q == $past(state_q) || state_q == LPM_RUN))
    else $error("mode changed while asleep"); // R3

endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl #(
  parameter int PIN_W = 32,
  parameter int QW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  logic [1:0]       mode_sel,
  input  logic             irq,
  input  logic             nmi,
  input  logic [PIN_W-1:0] pins,
  input  logic [PIN_W-1:0] pin_wake_sel,
  input  logic [QW-1:0]    qual_len,
  input  logic             osc_tick,
  output logic [1:0]       lpm_state,
  output logic             clk_stop_req,
  output logic             wake_pulse
);

  logic pin_ok;
  logic deep;

  lpm_pin_qual #(.PIN_W(PIN_W), .QW(QW)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .arm      (deep),
    .pins     (pins),
    .sel      (pin_wake_sel),
    .qual_len (qual_len),
    .osc_tick (osc_tick),
    .pin_ok   (pin_ok)
  );

  lpm_wake_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .enter        (enter),
    .mode_sel     (mode_sel),
    .irq          (irq),
    .nmi          (nmi),
    .pin_ok       (pin_ok),
    .state_o      (lpm_state),
    .deep_o       (deep),
    .clk_stop_req (clk_stop_req),
    .wake_pulse   (wake_pulse)
  );

  AST_STOP_ONLY_DEEP: assert property (@(posedge clk) disable iff (rst)
    clk_stop_req |-> lpm_state[1]) else $error("clock stop outside deep state"); // R6

endmodule

// File: tb/lpm_wake_ctrl_tb.sv
module lpm_wake_ctrl_tb;

  localparam int PIN_W = 32;
  localparam int QW    = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enter = 1'b0;
  logic [1:0]       mode_sel = 2'b00;
  logic             irq = 1'b0;
  logic             nmi = 1'b0;
  logic [PIN_W-1:0] pins = '1;
  logic [PIN_W-1:0] pin_wake_sel = '0;
  logic [QW-1:0]    qual_len = '0;
  logic             osc_tick = 1'b1;
  logic [1:0]       lpm_state;
  logic             clk_stop_req;
  logic             wake_pulse;

  int n_chk = 0;
  int n_bad = 0;

  lpm_wake_ctrl #(.PIN_W(PIN_W), .QW(QW)) u_dut (
    .clk, .rst, .enter, .mode_sel, .irq, .nmi, .pins, .pin_wake_sel,
    .qual_len, .osc_tick, .lpm_state, .clk_stop_req, .wake_pulse
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enter = 1'b0; irq = 1'b0; nmi = 1'b0;
    pins = '1; pin_wake_sel = '0; osc_tick = 1'b1;
    cycles(2);
    rst = 1'b0;
  endtask

  task automatic go_mode(input logic [1:0] m);
    mode_sel = m; enter = 1'b1;
    @(negedge clk);
    enter = 1'b0;
  endtask

  // returns edges from pin going low until wake is seen, 0 if none
  task automatic wait_wake(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wake_pulse) begin n = i; break; end
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 state", lpm_state, 0);
    chk("R1 stop", clk_stop_req, 0);
    chk("R1 wake", wake_pulse, 0);
  endtask

  task automatic t_idle();
    do_reset();
    go_mode(2'b00);
    chk("R2 idle", lpm_state, 1);
    chk("R5 no stop", clk_stop_req, 0);
    pin_wake_sel = '1; pins = '0;
    cycles(80);
    chk("R5 pins ignored", lpm_state, 1);
    pins = '1;
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    chk("R4 irq wake state", lpm_state, 0);
    chk("R4 irq wake pulse", wake_pulse, 1);
    @(negedge clk);
    chk("R11 pulse ends", wake_pulse, 0);
    go_mode(2'b00);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    chk("R4 nmi wake pulse", wake_pulse, 1);
    chk("R4 nmi wake state", lpm_state, 0);
  endtask

  task automatic t_enter_and_reset();
    do_reset();
    go_mode(2'b01);
    chk("R2 standby", lpm_state, 2);
    chk("R6 stop standby", clk_stop_req, 1);
    go_mode(2'b00);
    chk("R3 enter ignored", lpm_state, 2);
    do_reset();
    chk("R1 reset from standby", lpm_state, 0);
    chk("R1 stop cleared", clk_stop_req, 0);
    go_mode(2'b11);
    chk("R2 halt 11", lpm_state, 3);
    chk("R6 stop halt", clk_stop_req, 1);
  endtask

  task automatic t_deep_irq(input logic [1:0] m, input int exp_state);
    do_reset();
    go_mode(m);
    irq = 1'b1; nmi = 1'b1;
    cycles(10);
    irq = 1'b0; nmi = 1'b0;
    chk("R7 int ignored", lpm_state, exp_state);
    chk("R7 no wake", wake_pulse, 0);
    chk("R6 still stopped", clk_stop_req, 1);
  endtask

  task automatic t_pin_wake(input logic [1:0] m, input int q, input int bitn);
    int n;
    do_reset();
    qual_len = QW'(q);
    pin_wake_sel = '0;
    pin_wake_sel[bitn] = 1'b1;
    go_mode(m);
    pins[bitn] = 1'b0;
    wait_wake(200, n);
    chk("R9 qualify edges", n, q + 3);
    chk("R9 back to run", lpm_state, 0);
    chk("R6 stop released", clk_stop_req, 0);
    pins = '1;
  endtask

  task automatic t_unselected();
    do_reset();
    qual_len = QW'(0);
    pin_wake_sel = 32'h0000_0008;
    go_mode(2'b01);
    pins = 32'hFFFF_FFF7 ^ 32'hFFFF_FFFF;
    pins = ~32'hFFFF_FFF7 | 32'h0000_0008;
    pins = 32'h0000_0008;
    cycles(100);
    chk("R8 unselected ignored", lpm_state, 2);
    pins = '1;
  endtask

  task automatic t_glitch();
    int n;
    do_reset();
    qual_len = QW'(4);
    pin_wake_sel = 32'h8000_0000;
    go_mode(2'b10);
    chk("R2 halt 10", lpm_state, 3);
    pins[31] = 1'b0;
    cycles(5);
    pins[31] = 1'b1;
    cycles(3);
    chk("R10 glitch no wake", lpm_state, 3);
    pins[31] = 1'b0;
    wait_wake(100, n);
    chk("R10 count restarts", n, 7);
    pins = '1;
  endtask

  task automatic t_tick_gate();
    int n;
    do_reset();
    qual_len = QW'(2);
    pin_wake_sel = 32'h0001_0000;
    go_mode(2'b01);
    osc_tick = 1'b0;
    pins[16] = 1'b0;
    cycles(20);
    chk("R10 no tick no count", lpm_state, 2);
    osc_tick = 1'b1;
    wait_wake(100, n);
    chk("R10 counts ticks only", n, 5);
    pins = '1;
  endtask

  initial begin
    t_reset_state();
    t_idle();
    t_enter_and_reset();
    t_deep_irq(2'b01, 2);
    t_deep_irq(2'b11, 3);
    t_pin_wake(2'b01, 0, 0);
    t_pin_wake(2'b11, 63, 5);
    t_pin_wake(2'b10, 5, 20);
    t_unselected();
    t_glitch();
    t_tick_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule